// File: doc/BRIEF.md
# Signed 16-by-8 Iterative Divider

This block divides a 16-bit two's-complement dividend (the A:B accumulator pair, A being the upper byte) by an 8-bit signed divisor. A normal result puts the signed quotient in B and the signed remainder in A. The block also produces the N, Z, V and C condition flags, a divide-by-zero trap request and a sign byte for an internal working register. The division itself runs as an unsigned restoring loop on the operand magnitudes, one quotient bit per cycle. The signs are applied when the loop ends.

The block sits inside a processor's execute stage. The sequencer raises `start` for one cycle with the operands, the timing mode and the current carry flag. It then waits for `done`. The total instruction length is data-dependent: it depends on the timing mode (native or emulation), on the operand signs and on the overflow class. The block reproduces that cycle count exactly, so the surrounding bus timing stays cycle-accurate. On a zero divisor the block only raises the trap request. The stacking sequence belongs to the sequencer.

Top module: `sdiv16x8`

## Requirements
- R1: `start` is accepted only while `busy` is low. The start cycle counts as cycle 1. `busy` is high from cycle 2 through the `done` cycle, and a `start` seen while `busy` is high has no effect on the results or the timing.
- R2: When the quotient magnitude is below 128, B holds the quotient truncated toward zero and A holds the remainder, which takes the dividend's sign. N is B bit 7, Z is set when B is zero, C is B bit 0, and V is 0.
- R3: When the quotient magnitude is 128..255, A holds the signed remainder (dividend's sign) and B holds the unsigned quotient magnitude. Z=0, N=0, V=1, and C is bit 0 of that magnitude.
- R4: When the quotient magnitude exceeds 255, {A,B} holds the 16-bit magnitude of the dividend. N is the dividend's sign bit, Z=0, V=1 and C=0.
- R5: A zero divisor leaves A and B equal to the dividend's upper and lower bytes. It gives Z=1, N=0, V=0, and C equal to `carry_in` as sampled at start. `trap_req` is high in the `done` cycle and in no other cycle.
- R6: Without overflow, the total length is 26 cycles in native mode (`native_mode`=1) and 27 in emulation mode. One cycle is added for a negative dividend and one more for a negative divisor.
- R7: The length from R6 is cut by 13 cycles on a magnitude over 255 and by 1 cycle on a magnitude of 128..255.
- R8: A zero divisor takes 26 cycles in native mode and 25 in emulation mode, whatever the operand signs.
- R9: `sign_byte` is 8'hFF when the divisor is nonzero, the operand signs differ and the quotient magnitude is nonzero. Otherwise it is 8'h00, which includes the zero-divisor case.
- R10: While reset is active, `busy`, `done` and `trap_req` are low and `sign_byte` is 8'h00.
- R11: `done` is a single-cycle pulse. After it, `res_a`, `res_b`, the flags and `sign_byte` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division (taken only when idle) |
| native_mode | input | 1 | 1 = native timing, 0 = emulation timing |
| carry_in | input | 1 | Current C flag, passed through on a zero divisor |
| dividend | input | 16 | Signed dividend, upper byte from A, lower from B |
| divisor | input | 8 | Signed divisor |
| busy | output | 1 | Division in progress, including the done cycle |
| done | output | 1 | One-cycle pulse on the final counted cycle |
| trap_req | output | 1 | Divide-by-zero trap request, valid with done |
| res_a | output | 8 | Result for accumulator A |
| res_b | output | 8 | Result for accumulator B |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| sign_byte | output | 8 | Quotient sign byte for the working register |

## Verification
Some properties are checked on every cycle:
- `done` is a lone pulse inside `busy`.
- `busy` holds until `done`.
- A trap always comes with Z=1, V=0 and N=0.
- An overflow never reports Z=1.
- The sign byte is only ever 00 or FF.
- Results hold while idle.
- The instruction length falls between 13 and 29 cycles.

Only the bench scenarios can show the exact length for each sign and overflow combination, and the precise A/B contents for each class. The corners covered include -32768/-1, divisor -128, quotients exactly at 127/128/255/256, and a zero quotient with differing signs. The bench also shows that a `start` held during a busy division changes nothing.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_ZERO   = 2'd1,
    CLS_RANGE  = 2'd2
  } div_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_HOLD = 2'd2
  } div_st_e;
endpackage

// File: rtl/sdiv_rst_sync.sv
module sdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sdiv_step.sv
// One restoring step: shift in the next dividend bit, try to subtract the divisor.
module sdiv_step #(
  parameter int QW = 8
) (
  input  logic [QW-1:0] rem_in,
  input  logic [QW-1:0] quo_in,
  input  logic [QW-1:0] dvs,
  output logic [QW-1:0] rem_out,
  output logic [QW-1:0] quo_out
);
  logic [QW:0] trial;
  logic [QW:0] diff;
  logic        fits;

  always_comb begin
    trial   = {rem_in, quo_in[QW-1]};
    diff    = trial - {1'b0, dvs};
    fits    = (trial >= {1'b0, dvs});
    rem_out = fits ? diff[QW-1:0] : trial[QW-1:0];
    quo_out = {quo_in[QW-2:0], fits};
  end
endmodule

// File: rtl/sdiv_format.sv
// Turns the stored magnitudes and class into register contents, flags and length.
module sdiv_format
  import sdiv_pkg::*;
#(
  parameter int QW            = 8,
  parameter int CW            = 5,
  parameter int NATIVE_BASE   = 26,
  parameter int EMUL_BASE     = 27,
  parameter int RANGE_CUT     = 13,
  parameter int TWOS_CUT      = 1,
  parameter int ZERO_EMUL_CUT = 2
) (
  input  div_cls_e         cls,
  input  logic             neg_dvd,
  input  logic             neg_dvs,
  input  logic             native,
  input  logic             cin,
  input  logic [2*QW-1:0]  dvd_raw,
  input  logic [QW-1:0]    rem,
  input  logic [QW-1:0]    quo,
  output logic [QW-1:0]    out_a,
  output logic [QW-1:0]    out_b,
  output logic             f_n,
  output logic             f_z,
  output logic             f_v,
  output logic             f_c,
  output logic [QW-1:0]    sign_out,
  output logic             is_trap,
  output logic [CW-1:0]    target
);
  localparam int DW = 2 * QW;

  logic            diff_sign;
  logic [DW-1:0]   dvd_mag;
  logic [QW-1:0]   rem_s;
  logic [QW-1:0]   quo_s;
  logic            twos_ovf;
  int              len;

  always_comb begin
    diff_sign = neg_dvd ^ neg_dvs;
    dvd_mag   = neg_dvd ? (~dvd_raw + 1'b1) : dvd_raw;
    rem_s     = neg_dvd ? (~rem + 1'b1) : rem;
    quo_s     = diff_sign ? (~quo + 1'b1) : quo;
    twos_ovf  = quo[QW-1];
    is_trap   = (cls == CLS_ZERO);

    out_a    = rem_s;
    out_b    = quo_s;
    f_n      = quo_s[QW-1];
    f_z      = (quo_s == '0);
    f_v      = 1'b0;
    f_c      = quo_s[0];
    sign_out = (diff_sign && (quo != '0)) ? '1 : '0;

    case (cls)
      CLS_ZERO: begin
        out_a    = dvd_raw[DW-1:QW];
        out_b    = dvd_raw[QW-1:0];
        f_n      = 1'b0;
        f_z      = 1'b1;
        f_v      = 1'b0;
        f_c      = cin;
        sign_out = '0;
      end
      CLS_RANGE: begin
        out_a    = dvd_mag[DW-1:QW];
        out_b    = dvd_mag[QW-1:0];
        f_n      = neg_dvd;
        f_z      = 1'b0;
        f_v      = 1'b1;
        f_c      = 1'b0;
        sign_out = diff_sign ? '1 : '0;
      end
      default: begin
        if (twos_ovf) begin
          out_b = quo;
          f_n   = 1'b0;
          f_z   = 1'b0;
          f_v   = 1'b1;
          f_c   = quo[0];
        end
      end
    endcase

    if (cls == CLS_ZERO) begin
      len = native ? NATIVE_BASE : (EMUL_BASE - ZERO_EMUL_CUT);
    end else begin
      len = native ? NATIVE_BASE : EMUL_BASE;
      len = len + int'(neg_dvd) + int'(neg_dvs);
      if (cls == CLS_RANGE) len = len - RANGE_CUT;
      else if (twos_ovf)    len = len - TWOS_CUT;
    end
    target = CW'(len);
  end
endmodule

// File: rtl/sdiv16x8.sv
module sdiv16x8
  import sdiv_pkg::*;
#(
  parameter int QW            = 8,
  parameter int NATIVE_BASE   = 26,
  parameter int EMUL_BASE     = 27,
  parameter int RANGE_CUT     = 13,
  parameter int TWOS_CUT      = 1,
  parameter int ZERO_EMUL_CUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             native_mode,
  input  logic             carry_in,
  input  logic [2*QW-1:0]  dividend,
  input  logic [QW-1:0]    divisor,
  output logic             busy,
  output logic             done,
  output logic             trap_req,
  output logic [QW-1:0]    res_a,
  output logic [QW-1:0]    res_b,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic [QW-1:0]    sign_byte
);
  localparam int DW = 2 * QW;
  localparam int CW = $clog2(EMUL_BASE + 4);
  localparam int SW = $clog2(QW);

  logic rst_ns;

  sdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  div_st_e         st_q, st_d;
  logic [CW-1:0]   cyc_q, cyc_d;
  logic [SW-1:0]   step_q, step_d;
  div_cls_e        cls_q, cls_d;
  logic            neg_dvd_q, neg_dvs_q, native_q, cin_q;
  logic [DW-1:0]   dvd_q;
  logic [QW-1:0]   dvs_mag_q;
  logic [QW-1:0]   rem_q, rem_d, quo_q, quo_d;

  logic            ld_en;
  logic            run_en;
  logic [DW-1:0]   in_dvd_mag;
  logic [QW-1:0]   in_dvs_mag;
  logic [QW-1:0]   stp_rem, stp_quo;
  logic [CW-1:0]   target;
  logic            fmt_trap;

  assign ld_en  = (st_q == ST_IDLE) && start;
  assign run_en = (st_q != ST_IDLE) || ld_en;

  sdiv_step #(.QW(QW)) u_step (
    .rem_in  (rem_q),
    .quo_in  (quo_q),
    .dvs     (dvs_mag_q),
    .rem_out (stp_rem),
    .quo_out (stp_quo)
  );

  always_comb begin
    in_dvd_mag = dividend[DW-1] ? (~dividend + 1'b1) : dividend;
    in_dvs_mag = divisor[QW-1]  ? (~divisor + 1'b1)  : divisor;
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_HOLD) && (cyc_q == target);

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    step_d = step_q;
    cls_d  = cls_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cyc_d  = CW'(2);
          step_d = '0;
          rem_d  = in_dvd_mag[DW-1:QW];
          quo_d  = in_dvd_mag[QW-1:0];
          if (divisor == '0) begin
            cls_d = CLS_ZERO;
            st_d  = ST_HOLD;
          end else if (in_dvd_mag[DW-1:QW] >= in_dvs_mag) begin
            cls_d = CLS_RANGE;
            st_d  = ST_HOLD;
          end else begin
            cls_d = CLS_NORMAL;
            st_d  = ST_DIV;
          end
        end
      end
      ST_DIV: begin
        cyc_d  = cyc_q + 1'b1;
        step_d = step_q + 1'b1;
        rem_d  = stp_rem;
        quo_d  = stp_quo;
        if (step_q == SW'(QW - 1)) st_d = ST_HOLD;
      end
      default: begin
        cyc_d = cyc_q + 1'b1;
        if (done) st_d = ST_IDLE;
      end
    endcase
  end

  // sequencing state
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      cyc_q  <= '0;
      step_q <= '0;
    end else if (run_en) begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      step_q <= step_d;
    end
  end

  // operand capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cls_q     <= CLS_NORMAL;
      neg_dvd_q <= 1'b0;
      neg_dvs_q <= 1'b0;
      native_q  <= 1'b0;
      cin_q     <= 1'b0;
      dvd_q     <= '0;
      dvs_mag_q <= '0;
    end else if (ld_en) begin
      cls_q     <= cls_d;
      neg_dvd_q <= dividend[DW-1];
      neg_dvs_q <= divisor[QW-1];
      native_q  <= native_mode;
      cin_q     <= carry_in;
      dvd_q     <= dividend;
      dvs_mag_q <= in_dvs_mag;
    end
  end

  // partial remainder and quotient
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (ld_en || (st_q == ST_DIV)) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
    end
  end

  sdiv_format #(
    .QW            (QW),
    .CW            (CW),
    .NATIVE_BASE   (NATIVE_BASE),
    .EMUL_BASE     (EMUL_BASE),
    .RANGE_CUT     (RANGE_CUT),
    .TWOS_CUT      (TWOS_CUT),
    .ZERO_EMUL_CUT (ZERO_EMUL_CUT)
  ) u_fmt (
    .cls      (cls_q),
    .neg_dvd  (neg_dvd_q),
    .neg_dvs  (neg_dvs_q),
    .native   (native_q),
    .cin      (cin_q),
    .dvd_raw  (dvd_q),
    .rem      (rem_q),
    .quo      (quo_q),
    .out_a    (res_a),
    .out_b    (res_b),
    .f_n      (flag_n),
    .f_z      (flag_z),
    .f_v      (flag_v),
    .f_c      (flag_c),
    .sign_out (sign_byte),
    .is_trap  (fmt_trap),
    .target   (target)
  );

  assign trap_req = done && fmt_trap;
endmodule

// File: rtl/sdiv16x8_chk.sv
module sdiv16x8_chk #(
  parameter int QW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          trap_req,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_v,
  input logic [QW-1:0] res_a,
  input logic [QW-1:0] res_b,
  input logic [QW-1:0] sign_byte
);
  logic [5:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lat <= '0;
    else if (!busy && start) lat <= 6'd2;
    else if (busy)          lat <= lat + 6'd1;
  end

  p_done_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_a) && $stable(res_b) && $stable(sign_byte)));

  p_trap_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (done && flag_z && !flag_v && !flag_n));

  p_no_ovf_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v) |-> !flag_z);

  p_sign_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((sign_byte == '0) || (sign_byte == '1)));

  p_len_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((lat >= 6'd13) && (lat <= 6'd29)));
endmodule

bind sdiv16x8 sdiv16x8_chk #(.QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .trap_req  (trap_req),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .res_a     (res_a),
  .res_b     (res_b),
  .sign_byte (sign_byte)
);

// File: tb/sim_sdiv16x8.sv
`timescale 1ns/1ps
module sim_sdiv16x8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        native_mode = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] dividend = '0;
  logic [7:0]  divisor = '0;
  logic        busy, done, trap_req;
  logic [7:0]  res_a, res_b, sign_byte;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sdiv16x8 u0 (
    .clk (clk), .rst_n (rst_n), .start (start), .native_mode (native_mode),
    .carry_in (carry_in), .dividend (dividend), .divisor (divisor),
    .busy (busy), .done (done), .trap_req (trap_req),
    .res_a (res_a), .res_b (res_b), .flag_n (flag_n), .flag_z (flag_z),
    .flag_v (flag_v), .flag_c (flag_c), .sign_byte (sign_byte)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // class: 0 normal, 1 zero divisor, 2 range overflow, 3 two's-complement overflow
  task automatic model(input logic [15:0] dvd, input logic [7:0] dvs,
                       input logic nat, input logic cin,
                       output logic [7:0] ea, output logic [7:0] eb,
                       output logic [3:0] enzvc, output logic [7:0] esg,
                       output int elat, output int ecls);
    int sd, sv, md, mv, qm, rm, base, negs, q;
    sd = int'($signed(dvd));
    sv = int'($signed(dvs));
    base = nat ? 26 : 27;
    negs = (sd < 0 ? 1 : 0) + (sv < 0 ? 1 : 0);
    if (sv == 0) begin
      ecls = 1; ea = dvd[15:8]; eb = dvd[7:0];
      enzvc = {1'b0, 1'b1, 1'b0, cin}; esg = 8'h00;
      elat = nat ? 26 : 25;
      return;
    end
    md = sd < 0 ? -sd : sd;
    mv = sv < 0 ? -sv : sv;
    qm = md / mv;
    rm = md % mv;
    esg = ((sd < 0) != (sv < 0) && qm != 0) ? 8'hFF : 8'h00;
    if (qm > 255) begin
      ecls = 2; ea = 8'(md >> 8); eb = 8'(md);
      enzvc = {(sd < 0), 1'b0, 1'b1, 1'b0};
      elat = base + negs - 13;
    end else if (qm >= 128) begin
      ecls = 3; ea = 8'(sd < 0 ? -rm : rm); eb = 8'(qm);
      enzvc = {1'b0, 1'b0, 1'b1, eb[0]};
      elat = base + negs - 1;
    end else begin
      ecls = 0;
      q  = ((sd < 0) != (sv < 0)) ? -qm : qm;
      ea = 8'(sd < 0 ? -rm : rm); eb = 8'(q);
      enzvc = {eb[7], (eb == 8'h00), 1'b0, eb[0]};
      elat = base + negs;
    end
  endtask

  task automatic run(input logic [15:0] dvd, input logic [7:0] dvs,
                     input logic nat, input logic cin, input bit jam);
    logic [7:0] ea, eb, esg, ha, hb, hs;
    logic [3:0] ef;
    int elat, ecls, k;
    string rd, rl;
    model(dvd, dvs, nat, cin, ea, eb, ef, esg, elat, ecls);
    case (ecls)
      1: begin rd = "R5"; rl = "R8"; end
      2: begin rd = "R4"; rl = "R7"; end
      3: begin rd = "R3"; rl = "R7"; end
      default: begin rd = "R2"; rl = "R6"; end
    endcase
    @(negedge clk);
    dividend = dvd; divisor = dvs; native_mode = nat; carry_in = cin; start = 1'b1;
    k = 1;
    @(negedge clk);
    k = 2;
    chk(busy === 1'b1, "R1", "busy in cycle 2", 32'(busy), 32'd1);
    if (jam) begin
      // R1: new operands offered while busy must be ignored
      dividend = ~dvd; divisor = dvs + 8'd3; native_mode = ~nat; carry_in = ~cin;
    end else begin
      start = 1'b0;
    end
    while (done !== 1'b1 && k < 60) begin
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k < 60, "R1", "watchdog on done", 32'(k), 32'(elat));
    chk(k == elat, rl, "instruction length", 32'(k), 32'(elat));
    chk({res_a, res_b} === {ea, eb}, rd, "A:B result", {16'h0, res_a, res_b}, {16'h0, ea, eb});
    chk({flag_n, flag_z, flag_v, flag_c} === ef, rd, "NZVC", 32'({flag_n, flag_z, flag_v, flag_c}), 32'(ef));
    chk(trap_req === (ecls == 1), "R5", "trap request", 32'(trap_req), 32'(ecls == 1));
    chk(sign_byte === esg, "R9", "sign byte", 32'(sign_byte), 32'(esg));
    ha = res_a; hb = res_b; hs = sign_byte;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R11", "done pulse width", 32'({done, busy}), 32'd0);
    @(negedge clk);
    chk({res_a, res_b, sign_byte} === {ha, hb, hs}, "R11", "results held",
        32'({res_a, res_b, sign_byte}), 32'({ha, hb, hs}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 global watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && trap_req === 1'b0, "R10", "control in reset",
        32'({busy, done, trap_req}), 32'd0);
    chk(sign_byte === 8'h00, "R10", "sign byte in reset", 32'(sign_byte), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 normal, all sign combinations, both modes
    run(16'd100,  8'd7,    1'b1, 1'b0, 1'b0);
    run(-16'sd100, 8'd7,   1'b0, 1'b0, 1'b0);
    run(16'd100,  -8'sd7,  1'b1, 1'b1, 1'b0);
    run(-16'sd100, -8'sd7, 1'b0, 1'b0, 1'b0);
    run(16'd5,    -8'sd7,  1'b1, 1'b0, 1'b0);   // zero quotient, R9 00
    run(-16'sd127, 8'd1,   1'b0, 1'b0, 1'b0);   // quotient -127
    run(16'd127,  8'd1,    1'b1, 1'b0, 1'b0);
    // R5/R8 zero divisor
    run(16'h1234, 8'd0, 1'b1, 1'b1, 1'b0);
    run(16'h8765, 8'd0, 1'b0, 1'b0, 1'b0);
    run(16'hF000, 8'd0, 1'b0, 1'b1, 1'b0);
    // R4 range overflow
    run(16'h7FFF, 8'd1,    1'b1, 1'b1, 1'b0);
    run(16'h8000, 8'hFF,   1'b0, 1'b1, 1'b0);   // -32768 / -1
    run(16'd1280, 8'd5,    1'b1, 1'b0, 1'b0);   // exactly 256
    run(16'h8000, 8'h80,   1'b1, 1'b0, 1'b0);   // -32768 / -128 = 256
    // R3 two's-complement overflow
    run(16'd128,  8'd1,    1'b0, 1'b0, 1'b0);
    run(16'd200,  8'd1,    1'b1, 1'b0, 1'b0);
    run(16'hFF01, 8'hFF,   1'b0, 1'b0, 1'b0);   // -255 / -1
    run(16'h7FFF, 8'h80,   1'b1, 1'b0, 1'b0);   // 32767 / -128
    run(16'h8080, 8'h80,   1'b0, 1'b0, 1'b0);   // -32640 / -128
    run(16'd1279, 8'd5,    1'b1, 1'b1, 1'b0);
    // R1 start held while busy with changing operands
    run(-16'sd1000, 8'd9,  1'b1, 1'b0, 1'b1);
    run(16'd1279, 8'd0,    1'b0, 1'b1, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      logic [7:0]  v;
      int sel;
      d = 16'($urandom);
      sel = int'($urandom % 8);
      if (sel == 0)      v = 8'd0;
      else if (sel < 4)  v = 8'($urandom % 16) | 8'd1;
      else if (sel == 4) v = 8'hF0 | 8'($urandom % 16);
      else               v = 8'($urandom);
      if (sel == 5) d = 16'($signed(8'($urandom)));
      run(d, v, 1'($urandom), 1'($urandom), (i % 37) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule